// File: doc/BRIEF.md
# FIFO Fill-Level and Idle-Timeout Interrupt Monitor

This block sits beside a 16-entry byte FIFO. A host side writes the FIFO and a local processor drains it. The block does not hold the FIFO data. It watches the stored byte count and the FIFO access strobes, and it produces two interrupt flags for the local processor.

The level flag tells the processor that enough bytes are waiting to be worth a burst read. The threshold is one of four fixed levels, chosen by a two-bit field of a write-only control byte.

The timeout flag catches data that is left in the FIFO below the threshold. An 8-bit down-counter is paced by an external tick strobe, not by the clock. Every FIFO write or read reloads the counter with the programmed interval. When the counter runs out while data is still waiting, the flag is latched until software deals with it.

Top module: `fifo_irq_mon`

## Requirements
- R1: After reset the timeout flag is 0 and the threshold selection is 1 byte. The level flag is then 0 for an empty FIFO and 1 for any nonzero count.
- R2: A control write loads the threshold select from control bits 7:6 with the encoding 00 = 1 byte, 01 = 4, 10 = 8 and 11 = 14. The other control bits are ignored. The new selection applies from the cycle after the write.
- R3: The level flag is 1 exactly when the FIFO count is at or above the selected threshold, in the same cycle as the count. It drops as soon as reads bring the count below the threshold.
- R4: With a nonzero count and no FIFO access, the timeout flag rises after the rising clock edge that samples the Nth tick counted from the last reload, where N is the programmed interval. Ticks 1 to N-1 leave it low.
- R5: Any FIFO write or read reloads the counter with the interval. This restarts the full N-tick window, and no timeout can be raised in that cycle.
- R6: While the count is zero the counter is held at the interval. Ticks during that time are not counted.
- R7: The timeout flag is sticky. Further ticks, and FIFO writes, leave it at 1. After the counter has run out, ticks do not raise the flag again until a reload occurs.
- R8: A FIFO read or a pulse on the clear input clears the timeout flag one cycle later. A FIFO write does not clear it.
- R9: An interval of 0 disables the timeout: the flag never rises, however many ticks arrive.
- R10: If the expiring tick and a clear pulse fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fifo_count_i | input | 5 | Number of bytes currently stored in the FIFO (0 to 16) |
| fifo_wr_i | input | 1 | One-cycle strobe for a FIFO write |
| fifo_rd_i | input | 1 | One-cycle strobe for a FIFO read |
| tick_i | input | 1 | One-cycle strobe that paces the timeout counter |
| tmo_clr_i | input | 1 | One-cycle strobe that clears the timeout flag |
| tmo_limit_i | input | 8 | Timeout interval in ticks, loaded on every reload |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_data_i | input | 8 | Control byte; bits 7:6 select the threshold |
| level_irq_o | output | 1 | Fill-level interrupt flag |
| tmo_irq_o | output | 1 | Idle-timeout interrupt flag |

## Verification
A threshold select register holding the wrong value shows on the level flag in the same cycle as the count crosses the affected level. For that reason the count is swept across each threshold boundary after every control write. An off-by-one, or a missed reload, in the timeout counter appears only as a flag that rises one tick early or one tick late. It can stay hidden for up to a full interval. The flag is therefore sampled both at tick N-1 and at tick N after a write, after a read, and after the FIFO leaves the empty state. A flag state that fails to stick or fails to clear shows up on the next cycle after a tick, a write, a read or a clear.

// File: rtl/fim_pkg.sv
package fim_pkg;

  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_LVL = 1 << SEL_W;

  typedef logic [SEL_W-1:0] thr_sel_t;

  // Fixed, non-linear threshold table indexed by the two-bit select.
  function automatic int unsigned lvl_of(input int unsigned sel);
    case (sel)
      0:       lvl_of = 1;
      1:       lvl_of = 4;
      2:       lvl_of = 8;
      default: lvl_of = 14;
    endcase
  endfunction

endpackage

// File: rtl/fim_rst_sync.sv
module fim_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/fim_thr_reg.sv
module fim_thr_reg
  import fim_pkg::*;
#(
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned SEL_LSB = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] data_i,
  output thr_sel_t          sel_o
);

  thr_sel_t sel_q;
  thr_sel_t sel_d;
  logic     sel_en;

  always_comb begin
    sel_en = we_i;
    sel_d  = data_i[SEL_LSB +: SEL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/fim_lvl_cmp.sv
module fim_lvl_cmp
  import fim_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] count_i,
  input  thr_sel_t         sel_i,
  output logic             hit_o
);

  logic [NUM_LVL-1:0] hit_vec;

  // One comparator per selectable level; the select picks the result.
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_cmp
    localparam int unsigned LVL = lvl_of(g);
    assign hit_vec[g] = (count_i >= CNT_W'(LVL));
  end

  assign hit_o = hit_vec[sel_i];

endmodule

// File: rtl/fim_tmo_timer.sv
module fim_tmo_timer #(
  parameter int unsigned TMO_W = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             flag_o
);

  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             cnt_en, flag_en;
  logic             reload, running, expire;

  always_comb begin
    reload  = wr_i | rd_i | (count_i == '0);
    running = tick_i & (cnt_q != '0);
    expire  = ~reload & tick_i & (cnt_q == ONE);

    cnt_en = reload | running;
    cnt_d  = reload ? limit_i : (cnt_q - ONE);

    flag_en = rd_i | clr_i | expire;
    flag_d  = expire;  // a set in the same cycle beats a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/fifo_irq_mon.sv
module fifo_irq_mon
  import fim_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TMO_W   = 8,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned SEL_LSB = 6,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic              fifo_wr_i,
  input  logic              fifo_rd_i,
  input  logic              tick_i,
  input  logic              tmo_clr_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  output logic              level_irq_o,
  output logic              tmo_irq_o
);

  logic     rst_n;
  thr_sel_t thr_sel;

  fim_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  fim_thr_reg #(.CTRL_W(CTRL_W), .SEL_LSB(SEL_LSB)) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (ctrl_we_i),
    .data_i (ctrl_data_i),
    .sel_o  (thr_sel)
  );

  fim_lvl_cmp #(.CNT_W(CNT_W)) u_lvl (
    .count_i (fifo_count_i),
    .sel_i   (thr_sel),
    .hit_o   (level_irq_o)
  );

  fim_tmo_timer #(.TMO_W(TMO_W), .CNT_W(CNT_W)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .count_i (fifo_count_i),
    .wr_i    (fifo_wr_i),
    .rd_i    (fifo_rd_i),
    .tick_i  (tick_i),
    .clr_i   (tmo_clr_i),
    .limit_i (tmo_limit_i),
    .flag_o  (tmo_irq_o)
  );

endmodule

// File: rtl/fifo_irq_mon_chk.sv
module fifo_irq_mon_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] fifo_count_i,
  input logic             fifo_wr_i,
  input logic             fifo_rd_i,
  input logic             tick_i,
  input logic             tmo_clr_i,
  input logic             level_irq_o,
  input logic             tmo_irq_o
);

  // R3
  empty_no_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_i == '0) |-> !level_irq_o);

  // R3
  full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_i >= CNT_W'(14)) |-> level_irq_o);

  // R8
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i |=> !tmo_irq_o);

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_irq_o && !fifo_rd_i && !tmo_clr_i) |=> tmo_irq_o);

  // R5
  write_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_i && !tmo_irq_o) |=> !tmo_irq_o);

  // R6
  empty_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fifo_count_i == '0) && !tmo_irq_o) |=> !tmo_irq_o);

  // R4
  set_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !tmo_irq_o) |=> !tmo_irq_o);

endmodule

bind fifo_irq_mon fifo_irq_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_count_i (fifo_count_i),
  .fifo_wr_i    (fifo_wr_i),
  .fifo_rd_i    (fifo_rd_i),
  .tick_i       (tick_i),
  .tmo_clr_i    (tmo_clr_i),
  .level_irq_o  (level_irq_o),
  .tmo_irq_o    (tmo_irq_o)
);

// File: tb/fifo_irq_mon_tb_top.sv
module fifo_irq_mon_tb_top;

  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] fifo_count_i;
  logic       fifo_wr_i, fifo_rd_i, tick_i, tmo_clr_i, ctrl_we_i;
  logic [7:0] tmo_limit_i, ctrl_data_i;
  logic       level_irq_o, tmo_irq_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  fifo_irq_mon dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_count_i (fifo_count_i),
    .fifo_wr_i    (fifo_wr_i),
    .fifo_rd_i    (fifo_rd_i),
    .tick_i       (tick_i),
    .tmo_clr_i    (tmo_clr_i),
    .tmo_limit_i  (tmo_limit_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_data_i  (ctrl_data_i),
    .level_irq_o  (level_irq_o),
    .tmo_irq_o    (tmo_irq_o)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic pulse_wr();
    fifo_wr_i = 1'b1; @(negedge clk_i); fifo_wr_i = 1'b0;
  endtask

  task automatic pulse_rd();
    fifo_rd_i = 1'b1; @(negedge clk_i); fifo_rd_i = 1'b0;
  endtask

  task automatic pulse_clr();
    tmo_clr_i = 1'b1; @(negedge clk_i); tmo_clr_i = 1'b0;
  endtask

  task automatic set_sel(input logic [1:0] sel, input logic [5:0] junk);
    ctrl_data_i = {sel, junk};
    ctrl_we_i   = 1'b1;
    @(negedge clk_i);
    ctrl_we_i   = 1'b0;
    ctrl_data_i = 8'h00;
  endtask

  task automatic t_reset();
    fifo_count_i = 5'd0; #1;
    chk(level_irq_o, 1'b0, "R1", "level empty after reset");
    chk(tmo_irq_o,   1'b0, "R1", "timeout after reset");
    fifo_count_i = 5'd1; #1;
    chk(level_irq_o, 1'b1, "R1", "default threshold of 1");
    fifo_count_i = 5'd0;
  endtask

  task automatic t_thresholds();
    int lvl;
    for (int s = 0; s < 4; s++) begin
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      set_sel(2'(s), 6'b101101);  // R2 low bits are junk
      fifo_count_i = 5'(lvl - 1); #1;
      chk(level_irq_o, 1'b0, "R2", $sformatf("sel %0d below level", s));
      fifo_count_i = 5'(lvl); #1;
      chk(level_irq_o, 1'b1, "R2", $sformatf("sel %0d at level", s));
      fifo_count_i = 5'd16; #1;
      chk(level_irq_o, 1'b1, "R3", $sformatf("sel %0d full", s));
      fifo_count_i = 5'(lvl - 1); #1;
      chk(level_irq_o, 1'b0, "R3", $sformatf("sel %0d drained below", s));
    end
    set_sel(2'b01, 6'b111111);
    fifo_count_i = 5'd3; #1;
    chk(level_irq_o, 1'b0, "R2", "junk bits ignored, 3 < 4");
    set_sel(2'b00, 6'b000000);
    fifo_count_i = 5'd0;
  endtask

  task automatic t_timeout();
    fifo_count_i = 5'd3;
    pulse_wr();
    ticks(4);
    chk(tmo_irq_o, 1'b0, "R4", "after N-1 ticks");
    ticks(1);
    chk(tmo_irq_o, 1'b1, "R4", "after N ticks");
    ticks(3);
    chk(tmo_irq_o, 1'b1, "R7", "sticky under ticks");
    pulse_wr();
    chk(tmo_irq_o, 1'b1, "R8", "write does not clear");
    pulse_rd();
    chk(tmo_irq_o, 1'b0, "R8", "read clears");
  endtask

  task automatic t_restart();
    fifo_count_i = 5'd3;
    pulse_wr();
    ticks(3);
    pulse_wr();
    ticks(4);
    chk(tmo_irq_o, 1'b0, "R5", "write restarts window");
    ticks(1);
    chk(tmo_irq_o, 1'b1, "R5", "fires N ticks after restart");
    pulse_rd();
    ticks(4);
    chk(tmo_irq_o, 1'b0, "R5", "read restarts window");
    ticks(1);
    chk(tmo_irq_o, 1'b1, "R5", "fires N ticks after read");
    pulse_clr();
    chk(tmo_irq_o, 1'b0, "R8", "clear strobe clears");
    ticks(6);
    chk(tmo_irq_o, 1'b0, "R7", "no re-fire after run-out");
  endtask

  task automatic t_empty();
    fifo_count_i = 5'd0;
    @(negedge clk_i);
    ticks(20);
    chk(tmo_irq_o, 1'b0, "R6", "no timeout while empty");
    fifo_count_i = 5'd2;
    @(negedge clk_i);
    ticks(4);
    chk(tmo_irq_o, 1'b0, "R6", "counter held while empty");
    ticks(1);
    chk(tmo_irq_o, 1'b1, "R6", "full interval after leaving empty");
    pulse_clr();
  endtask

  task automatic t_zero_limit();
    tmo_limit_i  = 8'd0;
    fifo_count_i = 5'd4;
    pulse_rd();
    ticks(300);
    chk(tmo_irq_o, 1'b0, "R9", "zero interval never fires");
    tmo_limit_i = 8'd5;
  endtask

  task automatic t_set_vs_clr();
    tmo_limit_i  = 8'd2;
    fifo_count_i = 5'd3;
    pulse_wr();
    ticks(1);
    tick_i = 1'b1; tmo_clr_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; tmo_clr_i = 1'b0;
    chk(tmo_irq_o, 1'b1, "R10", "set beats clear");
    pulse_clr();
    chk(tmo_irq_o, 1'b0, "R10", "later clear works");
    tmo_limit_i = 8'd5;
  endtask

  initial begin
    rst_ni = 1'b0;
    fifo_count_i = '0; fifo_wr_i = 0; fifo_rd_i = 0; tick_i = 0;
    tmo_clr_i = 0; ctrl_we_i = 0; ctrl_data_i = '0; tmo_limit_i = 8'd5;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_thresholds();
    t_timeout();
    t_restart();
    t_empty();
    t_zero_limit();
    t_set_vs_clr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule